// File: doc/BRIEF.md
# Write-Through L1 Data Cache with Valid/Invalid Coherence

This block is a private first-level data cache for one core, or for a pair of hardware threads sharing one core. The cache never holds dirty data: every store goes on to the shared last-level cache (LLC) through a small in-order write-through queue. Each line therefore needs only one coherence bit, valid or not. Replacing a line overwrites it without any writeback. A remote core's write reaches the cache as a snoop, and the snoop clears the matching line's valid flop in one cycle.

The cache is direct mapped with one word per line. A word address splits into an index (the low `IDX_W` bits) and a tag (the remaining upper bits). Each line stores an even-parity bit over its data word. A load that finds a parity mismatch drops the line and refetches the word from the LLC, which always holds the current copy. A mode input makes the pair of threads sharing the cache keep store atomicity. In that mode a thread cannot read a word that the other thread has stored until the LLC has acknowledged that store.

Loads and stores share one request port with a valid/ready handshake. Load data comes back on a separate response port. The LLC side has two channels. The first is a level-held fill request, answered by a one-cycle fill-data strobe. The second is the head of the write-through queue, which is removed when the LLC acknowledges it. The LLC acknowledges a store once it has written the word and invalidated the other caches' copies.

Top module: `l1wt_cache`

## Requirements
- R1: While reset is held and on the first cycle after it, `reqReady` is high and `rspValid`, `fillReq` and `wtValid` are low. No line is valid, so the first load of any address issues a fill.
- R2: A load that hits a valid line with matching parity raises `rspValid` with the line's data on the cycle after the request is accepted, and it issues no fill.
- R3: A load miss raises `fillReq` with the word address held on `fillAddr` until `fillValid` is seen. The load's response follows on the next cycle with `fillData`, and the line is then valid, so a repeated load hits.
- R4: Every accepted store enters the write-through queue and is presented on `wtValid`/`wtAddr`/`wtData` in program order. Each entry stays until `wtAck`. A store that hits also updates the local line, and a store that misses does not allocate a line.
- R5: A fill into a set that holds another tag replaces that line silently. The write-through port carries exactly one transfer per store and nothing for evictions or fills.
- R6: A snoop (`snpValid`) whose word address matches a valid line clears that line, so the next load of that address fetches from the LLC. A snoop with the same index but a different tag leaves the line valid.
- R7: A load that finds a stored parity mismatch drops the line, fetches the word from the LLC and returns the correct data. The refilled line then hits.
- R8: With `threadPairMode` high, a load by one thread to an address that has a queued, unacknowledged store from the other thread holds `reqReady` low until that store is acknowledged. The thread's own pending stores do not stall it, and with the mode low no such stall occurs.
- R9: A load miss to an address with any queued store stalls until that store has been acknowledged, so the fill returns the stored value.
- R10: A snoop to the address being filled, whether during the fill or in the same cycle as `fillValid`, still lets the load complete with the fill data, but it leaves the line invalid.
- R11: When the write-through queue holds `WTQ_DEPTH` stores, a further store is stalled by `reqReady` low until an acknowledgement frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadPairMode | input | 1 | Enables cross-thread store atomicity |
| reqValid | input | 1 | CPU request valid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqThread | input | 1 | Issuing thread |
| reqAddr | input | ADDR_W | Word address |
| reqWData | input | DATA_W | Store data |
| reqReady | output | 1 | Request accepted when high with reqValid |
| rspValid | output | 1 | Load response strobe |
| rspThread | output | 1 | Thread of the response |
| rspData | output | DATA_W | Load data |
| fillReq | output | 1 | Read request to the LLC, held until fillValid |
| fillAddr | output | ADDR_W | Fill word address |
| fillValid | input | 1 | Fill data strobe |
| fillData | input | DATA_W | Fill data |
| wtValid | output | 1 | Write-through entry present |
| wtAddr | output | ADDR_W | Write-through address |
| wtData | output | DATA_W | Write-through data |
| wtThread | output | 1 | Thread that issued the store |
| wtAck | input | 1 | LLC done, including remote invalidations; pops the entry |
| snpValid | input | 1 | Remote-write invalidation strobe |
| snpAddr | input | ADDR_W | Invalidated word address |
| faultValid | input | 1 | Fault injection: flips data bit 0 of a line, not its parity |
| faultAddr | input | ADDR_W | Index (low bits) of the line to corrupt |

## Verification
The bench uses the default parameters: a 10-bit word address, 16 sets and a four-entry write-through queue. With 16 sets, the addresses 0x013, 0x033 and 0x113 all map to one set, so eviction and the snoop-with-different-tag case can be reached directly. With four queue entries, the full-queue stall is reached by holding the acknowledgement across four stores. The same held acknowledgement keeps a store pending long enough to show the cross-thread stall in both states of the mode input. The bench's LLC model can also raise a snoop in the same cycle as the fill strobe, which exercises the race between a fill and a snoop to the same address.

// File: rtl/l1wt_pkg.sv
package l1wt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrl_state_e;

  // strobes from control to the line arrays
  typedef struct packed {
    logic fillWe;    // install fill word at fill index, set valid
    logic storeWe;   // overwrite data/parity at request index
    logic dropLine;  // clear valid at request index (parity error)
  } line_cmd_t;

endpackage

// File: rtl/l1wt_datapath.sv
module l1wt_datapath
  import l1wt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddr,
  input  line_cmd_t         cmd,
  output logic              lookPresent,
  output logic              lookHit,
  output logic              lookParErr,
  output logic [DATA_W-1:0] lookData
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [SETS-1:0]   validQ;
  logic [TAG_W-1:0]  tagQ  [SETS];
  logic [DATA_W-1:0] dataQ [SETS];
  logic              parQ  [SETS];

  logic [IDX_W-1:0] lookIdx, fillIdx, snpIdx, faultIdx;
  logic [TAG_W-1:0] lookTag, fillTag, snpTag;
  logic             snpHitLine;

  assign lookIdx  = lookAddr[IDX_W-1:0];
  assign lookTag  = lookAddr[ADDR_W-1:IDX_W];
  assign fillIdx  = fillAddr[IDX_W-1:0];
  assign fillTag  = fillAddr[ADDR_W-1:IDX_W];
  assign snpIdx   = snpAddr[IDX_W-1:0];
  assign snpTag   = snpAddr[ADDR_W-1:IDX_W];
  assign faultIdx = faultAddr[IDX_W-1:0];

  always_comb begin
    lookPresent = validQ[lookIdx] && (tagQ[lookIdx] == lookTag);
    lookData    = dataQ[lookIdx];
    lookParErr  = lookPresent && ((^dataQ[lookIdx]) != parQ[lookIdx]);
    lookHit     = lookPresent && !lookParErr;
    snpHitLine  = snpValid && validQ[snpIdx] && (tagQ[snpIdx] == snpTag);
  end

  // valid flops: a fill wins its own set; otherwise snoop or parity drop clears
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (cmd.fillWe && fillIdx == IDX_W'(s)) begin
          validQ[s] <= 1'b1;
        end else if (snpHitLine && snpIdx == IDX_W'(s)) begin
          validQ[s] <= 1'b0;
        end else if (cmd.dropLine && lookIdx == IDX_W'(s)) begin
          validQ[s] <= 1'b0;
        end
      end
    end
  end

  // tag, data and parity arrays carry no reset; valid gates them
  always_ff @(posedge clk) begin
    if (cmd.fillWe) begin
      tagQ[fillIdx]  <= fillTag;
      dataQ[fillIdx] <= fillData;
      parQ[fillIdx]  <= ^fillData;
    end
    if (cmd.storeWe) begin
      dataQ[lookIdx] <= storeData;
      parQ[lookIdx]  <= ^storeData;
    end
    if (faultValid) begin
      dataQ[faultIdx][0] <= ~dataQ[faultIdx][0];
    end
  end

  // R4: stores only write lines that are already present
  p_store_noalloc_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.storeWe |-> lookPresent);

  // R6: a matching snoop leaves the line invalid
  p_snoop_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (snpHitLine && !(cmd.fillWe && fillIdx == snpIdx)) |=> !validQ[$past(snpIdx)]);

  // R7: a parity drop leaves the line invalid
  p_parity_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dropLine && !cmd.fillWe) |=> !validQ[$past(lookIdx)]);

endmodule

// File: rtl/l1wt_wtq.sv
module l1wt_wtq #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushThread,
  input  logic              pop,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic              probeThread,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              headThread,
  output logic              probeHitAny,
  output logic              probeHitOther
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrQ   [DEPTH];
  logic [DATA_W-1:0] dataQ   [DEPTH];
  logic              thrQ    [DEPTH];
  logic [DEPTH-1:0]  entValid;
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign empty      = (entValid == '0);
  assign full       = (entValid == '1);
  assign headAddr   = addrQ[rdPtr];
  assign headData   = dataQ[rdPtr];
  assign headThread = thrQ[rdPtr];

  // per-slot comparators against the requesting address
  logic [DEPTH-1:0] slotHit, slotOther;
  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign slotHit[g]   = entValid[g] && (addrQ[g] == probeAddr);
    assign slotOther[g] = slotHit[g] && (thrQ[g] != probeThread);
  end
  assign probeHitAny   = |slotHit;
  assign probeHitOther = |slotOther;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      if (pop) begin
        entValid[rdPtr] <= 1'b0;
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
      if (push) begin
        entValid[wrPtr] <= 1'b1;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
      thrQ[wrPtr]  <= pushThread;
    end
  end

  // R11: control never pushes into a full queue
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R4: the LLC only acknowledges an entry that exists
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/l1wt_ctrl.sv
module l1wt_ctrl
  import l1wt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              threadPairMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqThread,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic              lookPresent,
  input  logic              lookHit,
  input  logic              lookParErr,
  input  logic [DATA_W-1:0] lookData,
  input  logic              qFull,
  input  logic              qHitAny,
  input  logic              qHitOther,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output line_cmd_t         cmd,
  output logic              qPush,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              rspValid,
  output logic              rspThread,
  output logic [DATA_W-1:0] rspData
);

  ctrl_state_e       stateQ;
  logic [ADDR_W-1:0] fillAddrQ;
  logic              fillThreadQ;
  logic              abortQ;
  logic              accept, snpOnFill;

  always_comb begin
    reqReady = 1'b0;
    if (stateQ == ST_IDLE) begin
      if (reqWrite) reqReady = !qFull;
      else if (lookHit) reqReady = !(threadPairMode && qHitOther);
      else reqReady = !qHitAny;
    end
    accept    = reqValid && reqReady;
    snpOnFill = snpValid && (snpAddr == fillAddrQ);

    cmd.storeWe  = accept && reqWrite && lookPresent;
    cmd.dropLine = accept && !reqWrite && lookParErr;
    cmd.fillWe   = (stateQ == ST_FILL) && fillValid && !abortQ && !snpOnFill;
    qPush        = accept && reqWrite;
  end

  assign fillReq  = (stateQ == ST_FILL);
  assign fillAddr = fillAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      fillAddrQ   <= '0;
      fillThreadQ <= 1'b0;
      abortQ      <= 1'b0;
      rspValid    <= 1'b0;
      rspThread   <= 1'b0;
      rspData     <= '0;
    end else begin
      rspValid <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (accept && !reqWrite) begin
            if (lookHit) begin
              rspValid  <= 1'b1;
              rspData   <= lookData;
              rspThread <= reqThread;
            end else begin
              stateQ      <= ST_FILL;
              fillAddrQ   <= reqAddr;
              fillThreadQ <= reqThread;
              abortQ      <= snpValid && (snpAddr == reqAddr);
            end
          end
        end
        ST_FILL: begin
          if (snpOnFill) abortQ <= 1'b1;
          if (fillValid) begin
            stateQ    <= ST_IDLE;
            rspValid  <= 1'b1;
            rspData   <= fillData;
            rspThread <= fillThreadQ;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R8: in pair mode no load is taken over the other thread's pending store
  p_pair_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && threadPairMode) |-> !qHitOther);

  // R9: a load miss is only taken once no store to that word is queued
  p_miss_drained_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && !lookHit) |-> !qHitAny);

  // R3: a returning fill completes the load on the next cycle
  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillValid) |=> (rspValid && !fillReq));

endmodule

// File: rtl/l1wt_cache.sv
module l1wt_cache
  import l1wt_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int WTQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              threadPairMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqThread,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspThread,
  output logic [DATA_W-1:0] rspData,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  output logic              wtValid,
  output logic [ADDR_W-1:0] wtAddr,
  output logic [DATA_W-1:0] wtData,
  output logic              wtThread,
  input  logic              wtAck,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddr
);

  line_cmd_t         cmd;
  logic              lookPresent, lookHit, lookParErr;
  logic [DATA_W-1:0] lookData;
  logic              qPush, qEmpty, qFull, qHitAny, qHitOther;

  assign wtValid = !qEmpty;

  l1wt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .lookAddr(reqAddr), .storeData(reqWData),
    .fillAddr(fillAddr), .fillData(fillData),
    .snpValid(snpValid), .snpAddr(snpAddr),
    .faultValid(faultValid), .faultAddr(faultAddr),
    .cmd(cmd),
    .lookPresent(lookPresent), .lookHit(lookHit),
    .lookParErr(lookParErr), .lookData(lookData)
  );

  l1wt_wtq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WTQ_DEPTH)) u_wtq (
    .clk(clk), .rstN(rstN),
    .push(qPush), .pushAddr(reqAddr), .pushData(reqWData), .pushThread(reqThread),
    .pop(wtValid && wtAck),
    .probeAddr(reqAddr), .probeThread(reqThread),
    .empty(qEmpty), .full(qFull),
    .headAddr(wtAddr), .headData(wtData), .headThread(wtThread),
    .probeHitAny(qHitAny), .probeHitOther(qHitOther)
  );

  l1wt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .threadPairMode(threadPairMode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqThread(reqThread),
    .reqAddr(reqAddr), .reqReady(reqReady),
    .lookPresent(lookPresent), .lookHit(lookHit),
    .lookParErr(lookParErr), .lookData(lookData),
    .qFull(qFull), .qHitAny(qHitAny), .qHitOther(qHitOther),
    .fillValid(fillValid), .fillData(fillData),
    .snpValid(snpValid), .snpAddr(snpAddr),
    .cmd(cmd), .qPush(qPush),
    .fillReq(fillReq), .fillAddr(fillAddr),
    .rspValid(rspValid), .rspThread(rspThread), .rspData(rspData)
  );

endmodule

// File: tb/l1wt_cache_tb.sv
module l1wt_cache_tb;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int QD = 4;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic threadPairMode = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqThread = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWData = '0;
  logic reqReady, rspValid, rspThread, fillReq, wtValid, wtThread;
  logic [DW-1:0] rspData, wtData;
  logic [AW-1:0] fillAddr, wtAddr;
  logic fillValid = 1'b0;
  logic [DW-1:0] fillData = '0;
  logic wtAck = 1'b0;
  logic snpA = 1'b0, snpB = 1'b0;
  logic [AW-1:0] snpAddrA = '0, snpAddrB = '0;
  logic faultValid = 1'b0;
  logic [AW-1:0] faultAddr = '0;

  l1wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(4), .WTQ_DEPTH(QD)) u_dut (
    .clk(clk), .rstN(rstN), .threadPairMode(threadPairMode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqThread(reqThread),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqReady(reqReady),
    .rspValid(rspValid), .rspThread(rspThread), .rspData(rspData),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid), .fillData(fillData),
    .wtValid(wtValid), .wtAddr(wtAddr), .wtData(wtData), .wtThread(wtThread), .wtAck(wtAck),
    .snpValid(snpA | snpB), .snpAddr(snpB ? snpAddrB : snpAddrA),
    .faultValid(faultValid), .faultAddr(faultAddr)
  );

  int vectors = 0, fails = 0;
  int fillCount = 0, wtCount = 0, storesIssued = 0;
  bit ackHold = 1'b0, collide = 1'b0;
  logic [DW-1:0] llcMem [MEMSZ];
  logic [DW-1:0] refMem [MEMSZ];
  logic [DW-1:0] expQ [$];
  string         expTag [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // LLC fill model, optionally snooping the fill address in the fill cycle
  initial begin
    forever begin
      @(negedge clk);
      if (fillReq) begin
        fillCount++;
        repeat (2) @(negedge clk);
        fillValid = 1'b1;
        fillData  = llcMem[fillAddr];
        if (collide) begin snpB = 1'b1; snpAddrB = fillAddr; end
        @(negedge clk);
        fillValid = 1'b0;
        snpB = 1'b0;
      end
    end
  end

  // LLC write-through model
  initial begin
    forever begin
      @(negedge clk);
      if (wtValid && !ackHold) begin
        llcMem[wtAddr] = wtData;
        wtCount++;
        wtAck = 1'b1;
      end else begin
        wtAck = 1'b0;
      end
    end
  end

  // response monitor: pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected response", rspData, 0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          chk(rspData === e, t, rspData, e);
        end
      end
    end
  end

  task automatic startReq(input bit wr, input bit th, input int a, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqThread = th;
    reqAddr = AW'(a); reqWData = d;
    if (wr) begin refMem[a] = d; storesIssued++; end
    else begin expQ.push_back(refMem[a]); expTag.push_back(tag); end
  endtask

  task automatic waitAccept();
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReq(input bit wr, input bit th, input int a, input logic [DW-1:0] d, input string tag);
    startReq(wr, th, a, d, tag);
    waitAccept();
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic remoteWrite(input int a, input logic [DW-1:0] d);
    llcMem[a] = d; refMem[a] = d;
    @(negedge clk); snpA = 1'b1; snpAddrA = AW'(a);
    @(negedge clk); snpA = 1'b0;
  endtask

  task automatic snoopOnly(input int a);
    @(negedge clk); snpA = 1'b1; snpAddrA = AW'(a);
    @(negedge clk); snpA = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual %0d expected 0 hung cycles", 100000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int f0;
    int w0;
    for (int i = 0; i < MEMSZ; i++) begin
      llcMem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      refMem[i] = llcMem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1 reqReady in reset", reqReady, 1);
    chk(rspValid === 1'b0 && fillReq === 1'b0 && wtValid === 1'b0, "R1 outputs idle in reset",
        {rspValid, fillReq, wtValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(fillReq === 1'b0 && wtValid === 1'b0, "R1 idle after reset", {fillReq, wtValid}, 0);

    // R3 miss then R2 hit
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R3 fill data"); settle();
    chk(fillCount == f0 + 1, "R1 R3 first load fills", fillCount, f0 + 1);
    doReq(0, 0, 'h013, '0, "R2 hit data"); settle();
    chk(fillCount == f0 + 1, "R2 hit issues no fill", fillCount, f0 + 1);

    // R4 store hit writes through and updates the line
    w0 = wtCount;
    doReq(1, 0, 'h013, 32'hDEAD_0001, ""); settle();
    chk(wtCount == w0 + 1, "R4 store reaches LLC", wtCount, w0 + 1);
    chk(llcMem['h013] === 32'hDEAD_0001, "R4 LLC data", llcMem['h013], 32'hDEAD_0001);
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R4 store hit data"); settle();
    chk(fillCount == f0, "R4 store hit keeps line", fillCount, f0);

    // R4 store miss does not allocate
    doReq(1, 0, 'h025, 32'hBEEF_0025, ""); settle();
    f0 = fillCount;
    doReq(0, 0, 'h025, '0, "R4 store miss data"); settle();
    chk(fillCount == f0 + 1, "R4 store miss no allocate", fillCount, f0 + 1);

    // R9 load miss waits for a queued store to the same word
    ackHold = 1'b1;
    doReq(1, 0, 'h047, 32'hC0DE_0047, "");
    startReq(0, 0, 'h047, '0, "R9 drained fill data");
    for (int k = 0; k < 3; k++) begin
      #1 chk(reqReady === 1'b0, "R9 miss stalls on queued store", reqReady, 0);
      @(negedge clk);
    end
    ackHold = 1'b0;
    waitAccept(); settle();

    // R5 eviction by same-index load, no write-through traffic
    w0 = wtCount;
    doReq(0, 0, 'h033, '0, "R5 evicting fill data"); settle();
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R5 refetch data"); settle();
    chk(fillCount == f0 + 1, "R5 evicted line refetched", fillCount, f0 + 1);
    chk(wtCount == w0, "R5 eviction no writeback", wtCount, w0);

    // R6 snoop invalidation
    remoteWrite('h013, 32'h1234_5678);
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R6 post-snoop data"); settle();
    chk(fillCount == f0 + 1, "R6 snoop forces refill", fillCount, f0 + 1);
    snoopOnly('h113);
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R6 other-tag snoop data"); settle();
    chk(fillCount == f0, "R6 other tag keeps line", fillCount, f0);

    // R7 parity error refetch
    @(negedge clk); faultValid = 1'b1; faultAddr = AW'('h013);
    @(negedge clk); faultValid = 1'b0;
    f0 = fillCount;
    doReq(0, 0, 'h013, '0, "R7 refetched data"); settle();
    chk(fillCount == f0 + 1, "R7 parity error refetches", fillCount, f0 + 1);
    doReq(0, 0, 'h013, '0, "R7 after refetch data"); settle();
    chk(fillCount == f0 + 1, "R7 refetched line hits", fillCount, f0 + 1);

    // R10 snoop in the fill cycle
    collide = 1'b1;
    doReq(0, 0, 'h055, '0, "R10 colliding fill data"); settle();
    collide = 1'b0;
    f0 = fillCount;
    doReq(0, 0, 'h055, '0, "R10 reload data"); settle();
    chk(fillCount == f0 + 1, "R10 line left invalid", fillCount, f0 + 1);

    // R8 cross-thread atomicity
    threadPairMode = 1'b1;
    doReq(0, 0, 'h066, '0, "R8 warm data"); settle();
    ackHold = 1'b1;
    doReq(1, 0, 'h066, 32'hAAAA_0066, "");
    startReq(0, 0, 'h066, '0, "R8 own-thread data");
    #1 chk(reqReady === 1'b1, "R8 own store no stall", reqReady, 1);
    waitAccept();
    startReq(0, 1, 'h066, '0, "R8 other-thread data");
    for (int k = 0; k < 3; k++) begin
      #1 chk(reqReady === 1'b0, "R8 other thread stalls", reqReady, 0);
      @(negedge clk);
    end
    ackHold = 1'b0;
    waitAccept(); settle();
    threadPairMode = 1'b0;
    ackHold = 1'b1;
    doReq(1, 0, 'h066, 32'hBBBB_0066, "");
    startReq(0, 1, 'h066, '0, "R8 mode off data");
    #1 chk(reqReady === 1'b1, "R8 mode off no stall", reqReady, 1);
    waitAccept();
    ackHold = 1'b0;
    settle();

    // R11 full queue stall
    ackHold = 1'b1;
    for (int k = 0; k < QD; k++) doReq(1, 0, 'h070 + k, 32'h7000_0000 + k, "");
    startReq(1, 0, 'h070 + QD, 32'h7000_00FF, "");
    for (int k = 0; k < 2; k++) begin
      #1 chk(reqReady === 1'b0, "R11 full queue stalls store", reqReady, 0);
      @(negedge clk);
    end
    ackHold = 1'b0;
    waitAccept(); settle(); settle();
    chk(llcMem['h070 + QD] === 32'h7000_00FF, "R4 R11 last store in LLC",
        llcMem['h070 + QD], 32'h7000_00FF);
    chk(wtCount == storesIssued, "R5 one transfer per store", wtCount, storesIssued);
    chk(expQ.size() == 0, "R2 all loads answered", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule